// File: doc/BRIEF.md
# 8-bit Shift and Unary Arithmetic Unit

This block evaluates one single-operand operation per cycle on an 8-bit value: the five shift forms (left and right, logical or through carry, plus arithmetic right), one's and two's complement (with or without carry), increment (with or without carry), decrement, and two moves that depend on the carry. The result appears combinationally on `result`. A write-enable, `dst_we`, tells the surrounding register file whether the destination should take it. On the clock edge that accepts the operation, the result is also copied into an accumulator shadow register, and the carry, overflow and zero flags are updated.

Operations arrive with a plain `op_valid` qualifier. The unit accepts one operation on every clock edge where `op_valid` is high and never applies back-pressure, so it has no ready signal. The carry read by the through-carry, with-carry and conditional-move operations is the registered `flag_c` that the previous accepted operation left behind.

Top module: `sau_top`

## Requirements
- R1: Left shifts (code 0 logical, code 1 through carry) move the operand up one bit. Bit 0 takes 0 (code 0) or the old carry (code 1), and the new carry is the old bit 7.
- R2: Right shifts move the operand down one bit. Bit 7 takes 0 (code 2), the old carry (code 3) or the old bit 7 (code 4), and the new carry is the old bit 0.
- R3: After any shift, V is 1 exactly when bit 7 of the result differs from bit 7 of the operand.
- R4: One's complement (code 5) yields the bitwise NOT of the operand and updates only Z and the accumulator. C and V keep their values.
- R5: Two's complement (code 6) yields NOT(operand)+1, and the with-carry form (code 7) yields NOT(operand)+C. C becomes 1 only when the result is zero, and for code 7 only when the incoming carry was also 1.
- R6: Increment (code 8) yields operand+1 with C set exactly when the result is zero. Increment with carry (code 9) yields operand+C with C set only when the result is zero and the incoming carry was 1.
- R7: Decrement (code 10) yields operand-1. C becomes 0 when the result is 0xFF and 1 otherwise.
- R8: For codes 6 to 10, V is set on signed overflow: the result is 0x80 from a non-negative addend, or 0x7F from a decrement of 0x80.
- R9: The conditional moves (code 11: write when C is 0; code 12: write when C is 1) pass the operand to `result`. They raise `dst_we` only under their carry condition. They always load the accumulator with the operand and leave C and V unchanged.
- R10: On the edge that accepts an operation, the accumulator takes the result, and Z becomes 1 exactly when that result is zero.
- R11: Codes 13 to 15, and any cycle with `op_valid` low, keep `dst_we` low and leave the accumulator and all flags unchanged.
- R12: Reset clears the accumulator, C and V, and sets Z.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| op_valid | input | 1 | Operation present this cycle |
| op_sel | input | 4 | Operation code (see requirements) |
| operand | input | 8 | Source value |
| result | output | 8 | Combinational result of the current operation |
| dst_we | output | 1 | Destination write enable |
| acc | output | 8 | Accumulator shadow register |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| flag_z | output | 1 | Zero flag |

## Verification
On every cycle the assertions check that Z agrees with the accumulator, that idle or reserved cycles freeze the state, and that complement and moves keep C and V. They also check the move write-enable against the carry, the fill bit and carry of the logical left shift, and the carry after increment and decrement. Only the bench scenarios can show the exact result values and the overflow corner cases, such as 0x7F+1, 0x80-1 and the negation of 0x80. The same applies to the through-carry fills and to carry chains that set up across consecutive operations.

// File: rtl/sau_pkg.sv
`timescale 1ns/1ps
package sau_pkg;

  typedef enum logic [3:0] {
    OP_SHL   = 4'd0,
    OP_SHLC  = 4'd1,
    OP_SHR   = 4'd2,
    OP_SHRC  = 4'd3,
    OP_SHRA  = 4'd4,
    OP_NOT   = 4'd5,
    OP_NEG   = 4'd6,
    OP_NEGC  = 4'd7,
    OP_INC   = 4'd8,
    OP_INCC  = 4'd9,
    OP_DEC   = 4'd10,
    OP_MOVNC = 4'd11,
    OP_MOVC  = 4'd12
  } sau_op_e;

  typedef enum logic [1:0] {
    GRP_SHIFT = 2'd0,
    GRP_UNARY = 2'd1,
    GRP_MOVE  = 2'd2,
    GRP_NONE  = 2'd3
  } sau_grp_e;

  function automatic sau_grp_e op_group(input logic [3:0] code);
    sau_grp_e g;
    if (code <= 4'd4)       g = GRP_SHIFT;
    else if (code <= 4'd10) g = GRP_UNARY;
    else if (code <= 4'd12) g = GRP_MOVE;
    else                    g = GRP_NONE;
    return g;
  endfunction

endpackage

// File: rtl/sau_shift.sv
`timescale 1ns/1ps
module sau_shift #(
  parameter int DW = 8
) (
  input  logic [3:0]    op,
  input  logic [DW-1:0] a,
  input  logic          cin,
  output logic [DW-1:0] y,
  output logic          cout,
  output logic          vout
);
  import sau_pkg::*;
  localparam int MSB = DW - 1;

  logic fill_r;

  always_comb begin
    case (op)
      OP_SHRC: fill_r = cin;
      OP_SHRA: fill_r = a[MSB];
      default: fill_r = 1'b0;
    endcase
  end

  always_comb begin
    case (op)
      OP_SHL: begin
        y    = {a[MSB-1:0], 1'b0};
        cout = a[MSB];
      end
      OP_SHLC: begin
        y    = {a[MSB-1:0], cin};
        cout = a[MSB];
      end
      OP_SHR, OP_SHRC, OP_SHRA: begin
        y    = {fill_r, a[MSB:1]};
        cout = a[0];
      end
      default: begin
        y    = a;
        cout = cin;
      end
    endcase
    vout = y[MSB] ^ a[MSB];
  end

endmodule

// File: rtl/sau_unary.sv
`timescale 1ns/1ps
module sau_unary #(
  parameter int DW = 8
) (
  input  logic [3:0]    op,
  input  logic [DW-1:0] a,
  input  logic          cin,
  output logic [DW-1:0] y,
  output logic          cout,
  output logic          vout
);
  import sau_pkg::*;
  localparam int            MSB  = DW - 1;
  localparam logic [DW-1:0] ONE  = {{(DW-1){1'b0}}, 1'b1};
  localparam logic [DW-1:0] ZERO = '0;
  localparam logic [DW-1:0] ALL1 = '1;

  logic [DW-1:0] cin_ext;
  logic          y_zero;

  assign cin_ext = {{(DW-1){1'b0}}, cin};
  assign y_zero  = (y == ZERO);

  always_comb begin
    y    = a;
    cout = cin;
    vout = 1'b0;
    case (op)
      OP_NOT: begin
        y = ~a;
      end
      OP_NEG: begin
        y    = ~a + ONE;
        cout = y_zero;
        vout = a[MSB] & y[MSB];
      end
      OP_NEGC: begin
        y    = ~a + cin_ext;
        cout = y_zero & cin;
        vout = a[MSB] & y[MSB];
      end
      OP_INC: begin
        y    = a + ONE;
        cout = y_zero;
        vout = ~a[MSB] & y[MSB];
      end
      OP_INCC: begin
        y    = a + cin_ext;
        cout = y_zero & cin;
        vout = ~a[MSB] & y[MSB];
      end
      OP_DEC: begin
        y    = a - ONE;
        cout = (y != ALL1);
        vout = a[MSB] & ~y[MSB];
      end
      default: begin
        y    = a;
        cout = cin;
        vout = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/sau_state.sv
`timescale 1ns/1ps
module sau_state #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          upd_cv,
  input  logic [DW-1:0] nxt_res,
  input  logic          nxt_c,
  input  logic          nxt_v,
  output logic [DW-1:0] acc_q,
  output logic          c_q,
  output logic          v_q,
  output logic          z_q
);
  localparam logic [DW-1:0] ZERO = '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= ZERO;
      c_q   <= 1'b0;
      v_q   <= 1'b0;
      z_q   <= 1'b1;
    end else if (load) begin
      acc_q <= nxt_res;
      z_q   <= (nxt_res == ZERO);
      if (upd_cv) begin
        c_q <= nxt_c;
        v_q <= nxt_v;
      end
    end
  end

  // R10
  z_acc_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |-> (z_q == (acc_q == ZERO)));

  // R4
  cv_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !upd_cv) |=> (c_q == $past(c_q)) && (v_q == $past(v_q)));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(acc_q) && $stable(c_q) && $stable(v_q) && $stable(z_q));

endmodule

// File: rtl/sau_top.sv
`timescale 1ns/1ps
module sau_top #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [3:0]    op_sel,
  input  logic [DW-1:0] operand,
  output logic [DW-1:0] result,
  output logic          dst_we,
  output logic [DW-1:0] acc,
  output logic          flag_c,
  output logic          flag_v,
  output logic          flag_z
);
  import sau_pkg::*;
  localparam int            MSB  = DW - 1;
  localparam logic [DW-1:0] ZERO = '0;
  localparam logic [DW-1:0] ALL1 = '1;

  sau_grp_e      grp;
  logic [DW-1:0] sh_y, un_y;
  logic          sh_c, sh_v, un_c, un_v;
  logic          nxt_c, nxt_v;
  logic          load, upd_cv, move_ok;

  assign grp = op_group(op_sel);

  sau_shift #(.DW(DW)) u_shift (
    .op(op_sel), .a(operand), .cin(flag_c),
    .y(sh_y), .cout(sh_c), .vout(sh_v)
  );

  sau_unary #(.DW(DW)) u_unary (
    .op(op_sel), .a(operand), .cin(flag_c),
    .y(un_y), .cout(un_c), .vout(un_v)
  );

  always_comb begin
    case (grp)
      GRP_SHIFT: begin result = sh_y;    nxt_c = sh_c;   nxt_v = sh_v;   end
      GRP_UNARY: begin result = un_y;    nxt_c = un_c;   nxt_v = un_v;   end
      default:   begin result = operand; nxt_c = flag_c; nxt_v = flag_v; end
    endcase
  end

  assign move_ok = (op_sel == OP_MOVC) ? flag_c : ~flag_c;
  assign load    = op_valid && (grp != GRP_NONE);
  assign upd_cv  = (grp == GRP_SHIFT) || ((grp == GRP_UNARY) && (op_sel != OP_NOT));
  assign dst_we  = load && ((grp != GRP_MOVE) || move_ok);

  sau_state #(.DW(DW)) u_state (
    .clk(clk), .rst_n(rst_n), .load(load), .upd_cv(upd_cv),
    .nxt_res(result), .nxt_c(nxt_c), .nxt_v(nxt_v),
    .acc_q(acc), .c_q(flag_c), .v_q(flag_v), .z_q(flag_z)
  );

  // R9
  movnc_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == OP_MOVNC) |-> (dst_we == !flag_c));

  // R9
  movc_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == OP_MOVC) |-> (dst_we == flag_c));

  // R1
  shl_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == OP_SHL) |=> (acc[0] == 1'b0) && (flag_c == $past(operand[MSB])));

  // R6
  inc_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == OP_INC) |=> (flag_c == (acc == ZERO)));

  // R7
  dec_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_sel == OP_DEC) |=> (flag_c == (acc != ALL1)));

  // R11
  reserved_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (grp == GRP_NONE || !op_valid) |-> !dst_we);

endmodule

// File: tb/sau_top_test.sv
`timescale 1ns/1ps
module sau_top_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [3:0] op_sel = 4'd0;
  logic [7:0] operand = 8'h00;
  logic [7:0] result, acc;
  logic       dst_we, flag_c, flag_v, flag_z;
  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  sau_top #(.DW(8)) uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_sel(op_sel),
    .operand(operand), .result(result), .dst_we(dst_we), .acc(acc),
    .flag_c(flag_c), .flag_v(flag_v), .flag_z(flag_z)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run(input bit vld, input logic [3:0] op, input logic [7:0] val,
                     input bit chk_res, input logic [7:0] e_res, input bit e_we,
                     input logic [7:0] e_acc, input bit e_c, input bit e_v, input bit e_z,
                     input string tag);
    @(negedge clk);
    op_valid = vld; op_sel = op; operand = val;
    #1;
    if (chk_res) check({tag, " result"}, result, e_res);
    check({tag, " dst_we"}, {7'd0, dst_we}, {7'd0, e_we});
    @(posedge clk);
    #1;
    op_valid = 1'b0;
    check({tag, " acc"}, acc, e_acc);
    check({tag, " C"}, {7'd0, flag_c}, {7'd0, e_c});
    check({tag, " V"}, {7'd0, flag_v}, {7'd0, e_v});
    check({tag, " Z"}, {7'd0, flag_z}, {7'd0, e_z});
  endtask

  task automatic t_reset;
    check("R12 acc", acc, 8'h00);
    check("R12 C", {7'd0, flag_c}, 8'h00);
    check("R12 V", {7'd0, flag_v}, 8'h00);
    check("R12 Z", {7'd0, flag_z}, 8'h01);
    check("R11 we idle", {7'd0, dst_we}, 8'h00);
  endtask

  task automatic t_shift_left;
    run(1, 4'd0, 8'h00, 1, 8'h00, 1, 8'h00, 0, 0, 1, "R1 shl zero R10");
    run(1, 4'd0, 8'h81, 1, 8'h02, 1, 8'h02, 1, 1, 0, "R1 shl 81 R3");
    run(1, 4'd1, 8'h40, 1, 8'h81, 1, 8'h81, 0, 1, 0, "R1 shlc carry-in");
  endtask

  task automatic t_shift_right;
    run(1, 4'd2, 8'h01, 1, 8'h00, 1, 8'h00, 1, 0, 1, "R2 shr 01");
    run(1, 4'd3, 8'h02, 1, 8'h81, 1, 8'h81, 0, 1, 0, "R2 shrc fill R3");
    run(1, 4'd4, 8'h84, 1, 8'hC2, 1, 8'hC2, 0, 0, 0, "R2 shra sign");
    run(1, 4'd3, 8'h01, 1, 8'h00, 1, 8'h00, 1, 0, 1, "R2 shrc zero fill");
  endtask

  task automatic t_not;
    run(1, 4'd0, 8'h81, 1, 8'h02, 1, 8'h02, 1, 1, 0, "R4 setup");
    run(1, 4'd5, 8'hFF, 1, 8'h00, 1, 8'h00, 1, 1, 1, "R4 not FF");
    run(1, 4'd5, 8'h0F, 1, 8'hF0, 1, 8'hF0, 1, 1, 0, "R4 not 0F");
  endtask

  task automatic t_neg;
    run(1, 4'd6, 8'h00, 1, 8'h00, 1, 8'h00, 1, 0, 1, "R5 neg 00");
    run(1, 4'd6, 8'h05, 1, 8'hFB, 1, 8'hFB, 0, 0, 0, "R5 neg 05");
    run(1, 4'd6, 8'h80, 1, 8'h80, 1, 8'h80, 0, 1, 0, "R8 neg 80");
    run(1, 4'd0, 8'h80, 1, 8'h00, 1, 8'h00, 1, 1, 1, "R5 setup c1");
    run(1, 4'd7, 8'h00, 1, 8'h00, 1, 8'h00, 1, 0, 1, "R5 negc c1");
    run(1, 4'd0, 8'h00, 1, 8'h00, 1, 8'h00, 0, 0, 1, "R5 setup c0");
    run(1, 4'd7, 8'h00, 1, 8'hFF, 1, 8'hFF, 0, 0, 0, "R5 negc c0");
    run(1, 4'd7, 8'h80, 1, 8'h7F, 1, 8'h7F, 0, 0, 0, "R5 negc 80 c0");
  endtask

  task automatic t_inc;
    run(1, 4'd8, 8'hFF, 1, 8'h00, 1, 8'h00, 1, 0, 1, "R6 inc wrap");
    run(1, 4'd9, 8'hFF, 1, 8'h00, 1, 8'h00, 1, 0, 1, "R6 incc wrap");
    run(1, 4'd8, 8'h7F, 1, 8'h80, 1, 8'h80, 0, 1, 0, "R8 inc 7F");
    run(1, 4'd9, 8'h10, 1, 8'h10, 1, 8'h10, 0, 0, 0, "R6 incc c0");
  endtask

  task automatic t_dec;
    run(1, 4'd10, 8'h00, 1, 8'hFF, 1, 8'hFF, 0, 0, 0, "R7 dec wrap");
    run(1, 4'd10, 8'h01, 1, 8'h00, 1, 8'h00, 1, 0, 1, "R7 dec 01");
    run(1, 4'd10, 8'h80, 1, 8'h7F, 1, 8'h7F, 1, 1, 0, "R8 dec 80");
  endtask

  task automatic t_move;
    run(1, 4'd0,  8'h00, 1, 8'h00, 1, 8'h00, 0, 0, 1, "R9 setup c0");
    run(1, 4'd11, 8'h00, 1, 8'h00, 1, 8'h00, 0, 0, 1, "R9 movnc c0");
    run(1, 4'd12, 8'h5A, 1, 8'h5A, 0, 8'h5A, 0, 0, 0, "R9 movc c0");
    run(1, 4'd0,  8'h80, 1, 8'h00, 1, 8'h00, 1, 1, 1, "R9 setup c1");
    run(1, 4'd12, 8'h33, 1, 8'h33, 1, 8'h33, 1, 1, 0, "R9 movc c1");
    run(1, 4'd11, 8'h00, 1, 8'h00, 0, 8'h00, 1, 1, 1, "R9 movnc c1");
  endtask

  task automatic t_ignored;
    run(1, 4'd13, 8'hAA, 0, 8'h00, 0, 8'h00, 1, 1, 1, "R11 reserved 13");
    run(1, 4'd15, 8'h55, 0, 8'h00, 0, 8'h00, 1, 1, 1, "R11 reserved 15");
    run(0, 4'd0,  8'hFF, 0, 8'h00, 0, 8'h00, 1, 1, 1, "R11 not valid");
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    t_reset();
    t_shift_left();
    t_shift_right();
    t_not();
    t_neg();
    t_inc();
    t_dec();
    t_move();
    t_ignored();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

endmodule